// File: doc/BRIEF.md
# Direct-Mapped Translation Buffer with Page-Table Walk

This block turns 32-bit virtual addresses into physical addresses for a 4 KB page size. A requester offers one address at a time, together with the kind of access it wants to make: a data read, a data write or an instruction fetch. The block answers with a physical address and a flag that says whether the answer came straight from its own entry store. If the access is refused, it reports instead a protection fault or a page fault. The lower twelve address bits are the offset within the page and go through untouched.

The entry store has sixteen slots and is direct mapped. When a lookup misses, the block fetches the page-table entry for that virtual page through a memory-side read port. A resident entry is written into the slot, and the original request is then replayed against the store. A non-resident entry ends the request with a page fault and leaves the store as it was.

Each slot keeps the page's access rights and a dirty flag. A write that is allowed marks the page dirty. Any fault suppresses the address.

Top module: `tlb_translator`

## Requirements
- R1: Reset empties every slot and leaves the block in this state: `req_ready` high, `rsp_valid` low and `mem_req` low. The first access to any page after reset therefore goes to memory.
- R2: Bits 15:12 of the virtual address pick a slot, and bits 31:16 are compared with the tag stored in that slot. When the slot is valid and the tags match, the response arrives on the cycle after the request is accepted, with `rsp_hit` high and no memory read.
- R3: A successful translation returns the slot's 20-bit physical page number in bits 31:12 of `rsp_paddr`, followed by virtual address bits 11:0 unchanged.
- R4: On a miss the block raises `mem_req` with `mem_addr` = `pt_base` + 4 × (virtual address bits 31:12). Both are held until `mem_rvalid` is sampled high.
- R5: The page-table word has this layout. Bit 31 means the page is resident. Bits 30:29 hold the rights: 01 read-only, 11 read/write, 10 execute-only, 00 no access. Bits 28:20 must be zero. Bits 19:0 hold the physical page number. A resident word is installed with its dirty flag clear, and the request is then replayed; that response carries `rsp_hit` low.
- R6: A word that is not resident, or that has any of bits 28:20 set, ends the request with `rsp_page_fault` and `rsp_hit` low. No slot changes, so an earlier translation at that slot still hits afterwards.
- R7: `req_kind` is coded 00 read, 01 write, 10 execute and 11 reserved. A read needs read-only or read/write rights, a write needs read/write, and an execute needs execute-only. A reserved kind is always refused. A refusal raises `rsp_prot_fault`.
- R8: An allowed write sets the slot's dirty flag. `rsp_dirty` reports the slot's dirty flag after the access, so later reads of that page return 1. Faulting responses report 0.
- R9: A page whose slot holds a different tag misses, and its fill replaces the older page. A later access to the older page misses again.
- R10: Every accepted request gets exactly one `rsp_valid` pulse. At most one of the two fault flags is high, and `rsp_paddr` is zero whenever a fault is reported.
- R11: `req_ready` is low from acceptance of a missing request until its response, and `req_valid` is sampled only while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pt_base | input | 32 | Byte address of the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Answer came from the store without a walk |
| rsp_prot_fault | output | 1 | Rights forbid the access |
| rsp_page_fault | output | 1 | Page not resident or table word malformed |
| rsp_dirty | output | 1 | Dirty flag of the slot after the access |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | 32 | Page-table word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Page-table word |

## Verification
The assertions check four things on every cycle: that faults exclude each other and zero the address, that the page offset passes through, that allowed writes come back dirty, and that the table read request holds steady while ready is low. Other behaviours appear only in the bench's access sequences. These are the rights table for each access kind, the table-word address and layout, and eviction when two pages share a slot. They also include the finding that a page fault leaves an existing slot in place, and that reset empties the store.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int PPN_W     = 20;
    localparam int IDX_W     = 4;
    localparam int TAG_W     = VPN_W - IDX_W;
    localparam int PTE_W     = 32;
    localparam int PTE_VLD   = 31;
    localparam int PTE_RHI   = 30;
    localparam int PTE_RLO   = 29;
    localparam int PTE_RSVHI = 28;
    localparam int PTE_RSVLO = PPN_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_t;

    typedef enum logic [1:0] {
        RGT_NONE = 2'b00,
        RGT_RO   = 2'b01,
        RGT_XO   = 2'b10,
        RGT_RW   = 2'b11
    } rights_t;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        rights_t          rights;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WALK,
        ST_CHECK,
        ST_FILL,
        ST_FAULT,
        ST_RETRY
    } walk_state_t;
endpackage

// File: rtl/tlb_rights_check.sv
module tlb_rights_check
    import tlb_pkg::*;
(
    input  acc_t    kind,
    input  rights_t rights,
    output logic    allowed
);
    always_comb begin
        unique case (kind)
            ACC_READ:  allowed = (rights == RGT_RO) || (rights == RGT_RW);
            ACC_WRITE: allowed = (rights == RGT_RW);
            ACC_EXEC:  allowed = (rights == RGT_XO);
            default:   allowed = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output tlb_entry_t       rd_entry,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  tlb_entry_t       fill_entry,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx
);
    localparam int N_ENT = 1 << IDX_W;

    tlb_entry_t view [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        tlb_entry_t e_d, e_q;

        always_comb begin
            e_d = e_q;
            if (fill_en && (fill_idx == IDX_W'(g))) begin
                e_d = fill_entry;
            end else if (mark_en && (mark_idx == IDX_W'(g))) begin
                e_d.dirty = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                e_q <= '0;
            end else begin
                e_q <= e_d;
            end
        end

        assign view[g] = e_q;
    end

    assign rd_entry = view[rd_idx];

    AST_FILL_MARK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && mark_en)); // R8
endmodule

// File: rtl/tlb_translator.sv
module tlb_translator
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VA_W-1:0]  pt_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_prot_fault,
    output logic             rsp_page_fault,
    output logic             rsp_dirty,
    output logic [VA_W-1:0]  rsp_paddr,
    output logic             mem_req,
    output logic [VA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata
);
    localparam int ADDR_PAD = VA_W - VPN_W - 2;

    typedef struct packed {
        walk_state_t      st;
        logic [VA_W-1:0]  va;
        acc_t             kind;
        logic             pte_ok;
        rights_t          pte_rights;
        logic [PPN_W-1:0] pte_ppn;
        logic             mreq;
        logic [VA_W-1:0]  maddr;
        logic             rv;
        logic             hit;
        logic             prot;
        logic             pgf;
        logic             dirty;
        logic [VA_W-1:0]  pa;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [VA_W-1:0]  look_va;
    acc_t             look_kind;
    logic [VPN_W-1:0] look_vpn;
    logic [IDX_W-1:0] look_idx;
    logic [TAG_W-1:0] look_tag;
    tlb_entry_t       slot;
    logic             tag_match;
    logic             allowed;
    logic             fill_en;
    tlb_entry_t       fill_entry;
    logic             mark_en;

    // During a replay the held request is looked up; otherwise the incoming one
    assign look_va   = (ctl_q.st == ST_RETRY) ? ctl_q.va : req_vaddr;
    assign look_kind = (ctl_q.st == ST_RETRY) ? ctl_q.kind : acc_t'(req_kind);
    assign look_vpn  = look_va[VA_W-1:PAGE_BITS];
    assign look_idx  = look_vpn[IDX_W-1:0];
    assign look_tag  = look_vpn[VPN_W-1:IDX_W];
    assign tag_match = slot.valid && (slot.tag == look_tag);

    tlb_entry_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (look_idx),
        .rd_entry   (slot),
        .fill_en    (fill_en),
        .fill_idx   (ctl_q.va[PAGE_BITS +: IDX_W]),
        .fill_entry (fill_entry),
        .mark_en    (mark_en),
        .mark_idx   (look_idx)
    );

    tlb_rights_check u_rights (
        .kind    (look_kind),
        .rights  (slot.rights),
        .allowed (allowed)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rv   = 1'b0;
        fill_en    = 1'b0;
        mark_en    = 1'b0;
        fill_entry = '0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.va   = req_vaddr;
                    ctl_d.kind = acc_t'(req_kind);
                    if (tag_match) begin
                        ctl_d.rv  = 1'b1;
                        ctl_d.hit = 1'b1;
                        ctl_d.pgf = 1'b0;
                        if (allowed) begin
                            ctl_d.prot  = 1'b0;
                            ctl_d.pa    = {slot.ppn, look_va[PAGE_BITS-1:0]};
                            ctl_d.dirty = slot.dirty || (look_kind == ACC_WRITE);
                            mark_en     = (look_kind == ACC_WRITE) && !slot.dirty;
                        end else begin
                            ctl_d.prot  = 1'b1;
                            ctl_d.pa    = '0;
                            ctl_d.dirty = 1'b0;
                        end
                    end else begin
                        ctl_d.st    = ST_WALK;
                        ctl_d.mreq  = 1'b1;
                        ctl_d.maddr = pt_base + {{ADDR_PAD{1'b0}}, look_vpn, 2'b00};
                    end
                end
            end
            ST_WALK: begin
                if (mem_rvalid) begin
                    ctl_d.mreq       = 1'b0;
                    ctl_d.pte_ok     = mem_rdata[PTE_VLD] &&
                                       (mem_rdata[PTE_RSVHI:PTE_RSVLO] == '0);
                    ctl_d.pte_rights = rights_t'(mem_rdata[PTE_RHI:PTE_RLO]);
                    ctl_d.pte_ppn    = mem_rdata[PPN_W-1:0];
                    ctl_d.st         = ST_CHECK;
                end
            end
            ST_CHECK: begin
                ctl_d.st = ctl_q.pte_ok ? ST_FILL : ST_FAULT;
            end
            ST_FILL: begin
                fill_en           = 1'b1;
                fill_entry.valid  = 1'b1;
                fill_entry.dirty  = 1'b0;
                fill_entry.rights = ctl_q.pte_rights;
                fill_entry.tag    = ctl_q.va[VA_W-1:PAGE_BITS+IDX_W];
                fill_entry.ppn    = ctl_q.pte_ppn;
                ctl_d.st          = ST_RETRY;
            end
            ST_FAULT: begin
                ctl_d.rv    = 1'b1;
                ctl_d.hit   = 1'b0;
                ctl_d.prot  = 1'b0;
                ctl_d.pgf   = 1'b1;
                ctl_d.dirty = 1'b0;
                ctl_d.pa    = '0;
                ctl_d.st    = ST_IDLE;
            end
            ST_RETRY: begin
                ctl_d.rv  = 1'b1;
                ctl_d.hit = 1'b0;
                ctl_d.pgf = 1'b0;
                if (allowed) begin
                    ctl_d.prot  = 1'b0;
                    ctl_d.pa    = {slot.ppn, look_va[PAGE_BITS-1:0]};
                    ctl_d.dirty = slot.dirty || (look_kind == ACC_WRITE);
                    mark_en     = (look_kind == ACC_WRITE) && !slot.dirty;
                end else begin
                    ctl_d.prot  = 1'b1;
                    ctl_d.pa    = '0;
                    ctl_d.dirty = 1'b0;
                end
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.kind <= ACC_READ;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready      = (ctl_q.st == ST_IDLE);
    assign rsp_valid      = ctl_q.rv;
    assign rsp_hit        = ctl_q.hit;
    assign rsp_prot_fault = ctl_q.prot;
    assign rsp_page_fault = ctl_q.pgf;
    assign rsp_dirty      = ctl_q.dirty;
    assign rsp_paddr      = ctl_q.pa;
    assign mem_req        = ctl_q.mreq;
    assign mem_addr       = ctl_q.maddr;

    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot0({rsp_prot_fault, rsp_page_fault})); // R10
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_prot_fault || rsp_page_fault)) |-> (rsp_paddr == '0)); // R10
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_prot_fault && !rsp_page_fault) |->
        (rsp_paddr[PAGE_BITS-1:0] == ctl_q.va[PAGE_BITS-1:0])); // R3
    AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_prot_fault && !rsp_page_fault && (ctl_q.kind == ACC_WRITE))
        |-> rsp_dirty); // R8
    AST_HIT_NO_PGF: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !rsp_page_fault); // R6
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R4
    AST_WALK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready); // R11
endmodule

// File: tb/tlb_translator_test.sv
module tlb_translator_test;
    import tlb_pkg::*;

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  kind;
        logic        hit;
        logic [1:0]  fault;   // 0 none, 1 protection, 2 page
        logic        dirty;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{32'h00013_4A0, 2'd0, 1'b0, 2'd0, 1'b0, 8'd5},  // R5 fill read-only
        '{32'h00013_FFC, 2'd0, 1'b1, 2'd0, 1'b0, 8'd2},  // R2 hit
        '{32'h00013_000, 2'd1, 1'b1, 2'd1, 1'b0, 8'd7},  // R7 write to RO
        '{32'h00035_123, 2'd1, 1'b0, 2'd0, 1'b1, 8'd8},  // R8 write on walk
        '{32'h00035_800, 2'd0, 1'b1, 2'd0, 1'b1, 8'd8},  // R8 dirty kept
        '{32'h00027_0F0, 2'd2, 1'b0, 2'd0, 1'b0, 8'd5},  // R5 exec page
        '{32'h00027_0F0, 2'd0, 1'b1, 2'd1, 1'b0, 8'd7},  // R7 read of XO
        '{32'h00009_777, 2'd0, 1'b0, 2'd1, 1'b0, 8'd7},  // R7 no rights
        '{32'hF0031_010, 2'd0, 1'b0, 2'd2, 1'b0, 8'd6},  // R6 not resident
        '{32'hF0031_010, 2'd1, 1'b0, 2'd2, 1'b0, 8'd6},  // R6 not installed
        '{32'h10013_456, 2'd0, 1'b0, 2'd0, 1'b0, 8'd9},  // R9 evict
        '{32'h00013_456, 2'd0, 1'b0, 2'd0, 1'b0, 8'd9},  // R9 conflict miss
        '{32'h00035_000, 2'd2, 1'b1, 2'd1, 1'b0, 8'd7},  // R7 exec of RW
        '{32'h00027_000, 2'd1, 1'b1, 2'd1, 1'b0, 8'd7},  // R7 write of XO
        '{32'h00031_ABC, 2'd1, 1'b0, 2'd0, 1'b1, 8'd8},  // R8
        '{32'hF0031_ABC, 2'd0, 1'b0, 2'd2, 1'b0, 8'd6},  // R6 same slot
        '{32'h00031_321, 2'd0, 1'b1, 2'd0, 1'b1, 8'd6},  // R6 slot survived
        '{32'h00035_321, 2'd3, 1'b1, 2'd1, 1'b0, 8'd7}   // R7 reserved kind
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pt_base = 32'h0010_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid, rsp_hit, rsp_prot_fault, rsp_page_fault, rsp_dirty;
    logic [31:0] rsp_paddr;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    tlb_translator uut (
        .clk (clk), .rst_n (rst_n), .pt_base (pt_base),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_vaddr (req_vaddr), .req_kind (req_kind),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit),
        .rsp_prot_fault (rsp_prot_fault), .rsp_page_fault (rsp_page_fault),
        .rsp_dirty (rsp_dirty), .rsp_paddr (rsp_paddr),
        .mem_req (mem_req), .mem_addr (mem_addr),
        .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata)
    );

    function automatic logic [31:0] pte_of(input logic [19:0] vpn);
        logic resident;
        resident = (vpn[19:16] != 4'hF);
        return {resident, vpn[5:4], 9'd0, vpn ^ 20'h5A5A5};
    endfunction

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] va, input logic [1:0] kind,
                         input logic ehit, input logic [1:0] efault,
                         input logic edirty, input int rq);
        bit got = 0;
        bit walked = 0;
        int n = 0;
        logic [31:0] epa;
        epa = (efault == 2'd0) ? {va[31:12] ^ 20'h5A5A5, va[11:0]} : 32'h0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_kind  = kind;
        @(negedge clk);
        req_valid = 1'b0;
        while (!got && n < 60) begin
            if (rsp_valid) begin
                got = 1;
                chk(rsp_hit == ehit, rq, "hit", 32'(rsp_hit), 32'(ehit));
                chk(rsp_prot_fault == (efault == 2'd1), rq, "prot_fault",
                    32'(rsp_prot_fault), 32'(efault == 2'd1));
                chk(rsp_page_fault == (efault == 2'd2), rq, "page_fault",
                    32'(rsp_page_fault), 32'(efault == 2'd2));
                chk(rsp_paddr == epa, rq, "paddr", rsp_paddr, epa);
                chk(rsp_dirty == edirty, rq, "dirty", 32'(rsp_dirty), 32'(edirty));
                @(negedge clk);
                chk(rsp_valid == 1'b0, 10, "single pulse (R10)", 32'(rsp_valid), 32'h0);
            end else if (mem_req && !walked) begin
                walked = 1;
                chk(mem_addr == pt_base + {10'd0, va[31:12], 2'b00}, 4,
                    "mem_addr (R4)", mem_addr, pt_base + {10'd0, va[31:12], 2'b00});
                chk(req_ready == 1'b0, 11, "ready during walk (R11)", 32'(req_ready), 32'h0);
                repeat (2) @(negedge clk);
                chk(mem_req == 1'b1, 4, "mem_req held (R4)", 32'(mem_req), 32'h1);
                mem_rdata  = pte_of(va[31:12]);
                mem_rvalid = 1'b1;
                @(negedge clk);
                mem_rvalid = 1'b0;
                n++;
            end else begin
                @(negedge clk);
                n++;
            end
        end
        chk(got, rq, "response seen", 32'(got), 32'h1);
        chk(walked == !ehit, rq, "walk performed", 32'(walked), 32'(!ehit));
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, 1, "ready after reset (R1)", 32'(req_ready), 32'h1);
        chk(rsp_valid == 1'b0, 1, "no response after reset (R1)", 32'(rsp_valid), 32'h0);
        chk(mem_req == 1'b0, 1, "no mem_req after reset (R1)", 32'(mem_req), 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].va, VECS[i].kind, VECS[i].hit, VECS[i].fault,
                  VECS[i].dirty, int'(VECS[i].rq));
        end

        // R1: reset empties slots that were filled; new table base used (R4)
        @(negedge clk);
        rst_n = 1'b0;
        pt_base = 32'h0020_0400;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        apply(32'h00035_555, 2'd0, 1'b0, 2'd0, 1'b0, 1);   // R1 miss after reset
        apply(32'h00035_556, 2'd0, 1'b1, 2'd0, 1'b0, 2);   // R2 hit again, clean
        apply(32'h00031_00F, 2'd0, 1'b0, 2'd0, 1'b0, 1);   // R1 dirty cleared
        apply(32'h10013_FFF, 2'd0, 1'b0, 2'd0, 1'b0, 3);   // R3 offset at top

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule